// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes 24 external interrupt lines to processors as interrupt messages. Every line has its own redirection entry. The entry holds a vector, a delivery mode, a destination mode, a destination ID, a polarity, a trigger mode and a mask bit. Software cannot address an entry directly. It first writes a register number into the index register, and then reads or writes that register through the data register.

When an unmasked line becomes active, the block offers a message on a valid/ready output. The message carries the line's vector, destination and mode fields. Edge-mode lines latch each rising edge of their active level until the message for it is accepted. Level-mode lines set a remote-pending flag when their message is accepted, and send nothing more until an end-of-interrupt with a matching vector clears that flag. When several lines request at once, the lowest-numbered line goes first.

Top module: `irq_router`

## Requirements
- R1: With `bus_sel`=0, a write loads `bus_wdata[7:0]` into the index register and `bus_rdata` returns the index in bits 7:0. With `bus_sel`=1, a write goes to the register the index selects and `bus_rdata` shows that register combinationally. Unused indices read zero.
- R2: Index 0x00 is the identification register. Only bits 27:24 can be written, all other bits read zero, and it resets to zero.
- R3: Index 0x01 is the read-only version register. It reads the version 0x11 in bits 7:0 and the entry count minus one (23) in bits 23:16.
- R4: Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. The low word holds vector [7:0], delivery [10:8] (000 fixed, 100 NMI, 111 ExtINT), destination mode [11], polarity [13] (1 = active low), remote-pending [14] (read-only), trigger [15] (1 = level) and mask [16]. The high word holds the destination in [31:24]. All other bits read zero.
- R5: After reset every entry reads 0x0001_0000 in its low word and 0 in its high word, and no message is offered.
- R6: For an unmasked edge-mode line, a rising edge of the active level makes the block offer one message, starting the cycle after the edge is sampled. The message carries the line number, vector, destination, destination mode and delivery mode. An edge that occurs while the line is masked is dropped and does not fire later when the line is unmasked.
- R7: A line with polarity 1 is active while its input is low.
- R8: An unmasked level-mode line whose remote-pending bit is clear requests a message while it is active. Acceptance sets remote-pending, and while remote-pending is set the line requests nothing.
- R9: `eoi_valid` with `eoi_vector` clears remote-pending on every level-mode entry whose vector equals `eoi_vector`. Entries with a different vector keep their bit.
- R10: A message from an entry in NMI delivery mode carries vector 0, whatever the entry's vector field holds.
- R11: Among requesting lines the lowest-numbered one is offered. One message is accepted per cycle with both valid and ready high, and a pending edge message stays offered while ready is low.
- R12: A new edge on a line in the same cycle that its earlier edge message is accepted is kept pending, and a second message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_in | input | 24 | Interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver accepts the message |
| msg_line | output | 5 | Input line that the message comes from |
| msg_vector | output | 8 | Message vector (0 in NMI mode) |
| msg_dest | output | 8 | Destination ID |
| msg_dest_mode | output | 1 | Destination mode (0 physical, 1 logical) |
| msg_delivery | output | 3 | Delivery mode code |

## Verification
Two pairs of events can land in the same cycle. In the first, an edge line's message is accepted in the same cycle that the line shows a fresh rising edge. The bench holds ready low while the first message is offered, drops the line, and then raises ready and the line together. It passes only if a second message for that line follows. In the second, an end-of-interrupt clears remote-pending on two level lines that are still asserted. The bench expects both lines to send again, in ascending order, on the following cycles, and expects a third line with a different vector to stay silent and keep its flag.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N       = 24,
  parameter int VERSION = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_sel,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [N-1:0]         irq_in,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [$clog2(N)-1:0] msg_line,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_dest,
  output logic                 msg_dest_mode,
  output logic [2:0]           msg_delivery
);
  localparam int LW   = $clog2(N);
  localparam int BASE = 16;
  localparam logic [2:0] DLV_NMI = 3'b100;

  logic [7:0]   idx;
  logic [3:0]   chip_id;
  logic [7:0]   vec  [N];
  logic [7:0]   dest [N];
  logic [2:0]   dlv  [N];
  logic [N-1:0] dmode, pol, trig, mask, remote, pend, act_q;
  logic [N-1:0] act, req;
  logic [LW-1:0] sel, ent;
  logic          in_rng, hi, send;

  assign act    = irq_in ^ pol;
  assign req    = ~mask & ((trig & act_q & ~remote) | (~trig & pend));
  assign in_rng = (int'(idx) >= BASE) && (int'(idx) < BASE + 2*N);
  assign ent    = LW'((idx - 8'(BASE)) >> 1);
  assign hi     = idx[0];

  always_comb begin
    sel = '0;
    for (int i = N-1; i >= 0; i--)
      if (req[i]) sel = LW'(i);
  end

  assign msg_valid     = |req;
  assign send          = msg_valid & msg_ready;
  assign msg_line      = sel;
  assign msg_vector    = (dlv[sel] == DLV_NMI) ? 8'h00 : vec[sel];
  assign msg_dest      = dest[sel];
  assign msg_dest_mode = dmode[sel];
  assign msg_delivery  = dlv[sel];

  always_comb begin
    bus_rdata = '0;
    if (!bus_sel)           bus_rdata = {24'h0, idx};
    else if (idx == 8'h00)  bus_rdata = {4'h0, chip_id, 24'h0};
    else if (idx == 8'h01)  bus_rdata = {8'h0, 8'(N-1), 8'h0, 8'(VERSION)};
    else if (in_rng && hi)  bus_rdata = {dest[ent], 24'h0};
    else if (in_rng)        bus_rdata = {15'h0, mask[ent], trig[ent], remote[ent], pol[ent],
                                         1'b0, dmode[ent], dlv[ent], vec[ent]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      chip_id <= '0;
      for (int i = 0; i < N; i++) begin
        vec[i] <= '0; dest[i] <= '0; dlv[i] <= '0;
      end
      dmode <= '0; pol <= '0; trig <= '0; mask <= '1;
    end else if (bus_wr) begin
      if (!bus_sel) idx <= bus_wdata[7:0];
      else if (idx == 8'h00) chip_id <= bus_wdata[27:24];
      else if (in_rng) begin
        for (int i = 0; i < N; i++)
          if (ent == LW'(i)) begin
            if (hi) dest[i] <= bus_wdata[31:24];
            else begin
              vec[i]   <= bus_wdata[7:0];
              dlv[i]   <= bus_wdata[10:8];
              dmode[i] <= bus_wdata[11];
              pol[i]   <= bus_wdata[13];
              trig[i]  <= bus_wdata[15];
              mask[i]  <= bus_wdata[16];
            end
          end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0; pend <= '0; remote <= '0;
    end else begin
      act_q <= act;
      for (int i = 0; i < N; i++) begin
        if (send && sel == LW'(i)) pend[i] <= 1'b0;
        if (!trig[i] && !mask[i] && act[i] && !act_q[i]) pend[i] <= 1'b1;
        if (eoi_valid && trig[i] && vec[i] == eoi_vector) remote[i] <= 1'b0;
        if (send && sel == LW'(i) && trig[i]) remote[i] <= 1'b1;
      end
    end
  end

  AST_MSG_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !mask[msg_line]);                                            // R6
  AST_NMI_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_delivery == DLV_NMI) |-> msg_vector == 8'h00);           // R10
  AST_REMOTE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (send && trig[msg_line]) |=> remote[$past(msg_line)]);                     // R8
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (req & ((N'(1) << msg_line) - N'(1))) == '0);                // R11
  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !trig[msg_line] && !bus_wr) |=> msg_valid);    // R11

  for (genvar g = 0; g < N; g++) begin : g_eoi_chk
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && trig[g] && vec[g] == eoi_vector && !(send && sel == LW'(g)))
      |=> !remote[g]);                                                         // R9
  end
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_sel = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [23:0] lines = 0;
  logic        eoi_valid = 0;
  logic [7:0]  eoi_vector = 0;
  logic        msg_valid, msg_ready = 1, msg_dest_mode;
  logic [4:0]  msg_line;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_delivery;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_router i_irq_router (.clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
    .irq_in(lines), .eoi_valid, .eoi_vector, .msg_valid, .msg_ready, .msg_line,
    .msg_vector, .msg_dest, .msg_dest_mode, .msg_delivery);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] low_w(logic [7:0] v, logic [2:0] d, logic dm, logic p,
                                        logic t, logic m);
    return {15'h0, m, t, 1'b0, p, 1'b0, dm, d, v};
  endfunction

  function automatic logic [31:0] msg_w(logic [4:0] l, logic [7:0] v, logic [7:0] ds,
                                        logic dm, logic [2:0] d);
    return {7'h0, l, (d == 3'b100) ? 8'h00 : v, ds, dm, d};
  endfunction

  function automatic logic [31:0] cur_msg();
    return {7'h0, msg_line, msg_vector, msg_dest, msg_dest_mode, msg_delivery};
  endfunction

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr(logic s, logic [31:0] d);
    bus_sel = s; bus_wdata = d; bus_wr = 1; cyc(); bus_wr = 0;
  endtask
  task automatic reg_wr(logic [7:0] i, logic [31:0] d); wr(0, {24'h0, i}); wr(1, d); endtask
  task automatic reg_rd(logic [7:0] i, output logic [31:0] d);
    wr(0, {24'h0, i}); bus_sel = 1; #1 d = bus_rdata;
  endtask
  task automatic setup(int l, logic [7:0] v, logic [7:0] ds, logic dm, logic [2:0] d,
                       logic p, logic t, logic m);
    reg_wr(8'(16 + 2*l + 1), {ds, 24'h0});
    reg_wr(8'(16 + 2*l), low_w(v, d, dm, p, t, m));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R5 no message after reset", msg_valid, 0);
    reg_rd(8'h10, r); chk("R5 entry0 low reset", r, 32'h0001_0000);
    reg_rd(8'h3F, r); chk("R5 entry23 high reset", r, 0);
    reg_rd(8'h2E, r); chk("R5 entry15 low reset", r, 32'h0001_0000);

    reg_rd(8'h00, r); chk("R2 id reset", r, 0);
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, r); chk("R2 id writable field", r, 32'h0F00_0000);
    bus_sel = 0; #1 chk("R1 index readback", bus_rdata, 32'h0000_0000);
    reg_rd(8'h01, r); chk("R3 version", r, 32'h0017_0011);
    reg_rd(8'h40, r); chk("R1 unused index", r, 0);
    reg_wr(8'h40, 32'hFFFF_FFFF);
    reg_rd(8'h40, r); chk("R1 unused index stays zero", r, 0);
    bus_sel = 0; #1 chk("R1 index readback 0x40", bus_rdata, 32'h40);

    reg_wr(8'h1E, 32'hFFFF_FFFF);
    reg_rd(8'h1E, r); chk("R4 low word fields, remote read-only", r, 32'h0001_AFFF);
    reg_wr(8'h1F, 32'hABCD_EF12);
    reg_rd(8'h1F, r); chk("R4 high word destination", r, 32'hAB00_0000);
    setup(7, 0, 0, 0, 0, 0, 0, 1);

    for (int k = 0; k < 40; k++) begin
      int l; logic [7:0] v, ds; logic dm, p; logic [2:0] d;
      l = $urandom_range(0, 23); v = 8'($urandom_range(16, 255)); ds = 8'($urandom);
      dm = 1'($urandom); p = 1'($urandom); d = $urandom_range(0, 1) ? 3'b111 : 3'b000;
      lines[l] = p; cyc();
      setup(l, v, ds, dm, d, p, 0, 1);
      lines[l] = ~p; cyc();
      chk("R6 masked edge ignored", msg_valid, 0);
      lines[l] = p; cyc();
      reg_wr(8'(16 + 2*l), low_w(v, d, dm, p, 0, 0)); cyc();
      chk("R6 masked edge not remembered", msg_valid, 0);
      lines[l] = ~p; cyc();
      chk("R6 R7 message valid", msg_valid, 1);
      chk("R6 R7 message fields", cur_msg(), msg_w(5'(l), v, ds, dm, d));
      cyc();
      chk("R6 single message per edge", msg_valid, 0);
      lines[l] = p;
      reg_wr(8'(16 + 2*l), low_w(v, d, dm, p, 0, 1));
      lines[l] = 0; cyc();
    end

    setup(2, 8'h55, 8'h3C, 0, 3'b100, 0, 0, 0);
    lines[2] = 1; cyc();
    chk("R10 NMI vector zero", cur_msg(), msg_w(5'd2, 8'h00, 8'h3C, 0, 3'b100));
    chk("R10 NMI vector zero valid", msg_valid, 1);
    cyc(); lines[2] = 0; setup(2, 0, 0, 0, 0, 0, 0, 1);

    setup(9,  8'h60, 8'h01, 0, 0, 0, 1, 0);
    setup(10, 8'h60, 8'h02, 0, 0, 0, 1, 0);
    setup(11, 8'h61, 8'h03, 0, 0, 0, 1, 0);
    lines[11:9] = 3'b111; cyc();
    chk("R8 R11 level line 9 first", cur_msg(), msg_w(5'd9, 8'h60, 8'h01, 0, 0));
    cyc(); chk("R11 level line 10 next", cur_msg(), msg_w(5'd10, 8'h60, 8'h02, 0, 0));
    cyc(); chk("R11 level line 11 next", cur_msg(), msg_w(5'd11, 8'h61, 8'h03, 0, 0));
    cyc(); chk("R8 remote holds off level lines", msg_valid, 0);
    reg_rd(8'h22, r); chk("R8 remote bit set", r, low_w(8'h60, 0, 0, 0, 1, 0) | 32'h4000);
    chk("R8 still silent", msg_valid, 0);
    eoi_valid = 1; eoi_vector = 8'h60; cyc(); eoi_valid = 0;
    chk("R9 eoi re-arms line 9", cur_msg(), msg_w(5'd9, 8'h60, 8'h01, 0, 0));
    cyc(); chk("R9 eoi re-arms line 10", cur_msg(), msg_w(5'd10, 8'h60, 8'h02, 0, 0));
    cyc(); chk("R9 mismatched vector stays held", msg_valid, 0);
    reg_rd(8'h26, r); chk("R9 line 11 remote kept", r, low_w(8'h61, 0, 0, 0, 1, 0) | 32'h4000);
    lines[11:9] = 0; cyc();
    eoi_valid = 1; eoi_vector = 8'h60; cyc(); eoi_vector = 8'h61; cyc(); eoi_valid = 0;
    reg_rd(8'h26, r); chk("R9 line 11 remote cleared", r, low_w(8'h61, 0, 0, 0, 1, 0));
    for (int l = 9; l <= 11; l++) setup(l, 0, 0, 0, 0, 0, 0, 1);

    setup(20, 8'hA0, 8'h14, 1, 0, 1, 0, 0);
    setup(4,  8'h40, 8'h04, 0, 0, 0, 0, 0);
    lines[20] = 1; cyc();
    msg_ready = 0; lines[20] = 0; lines[4] = 1; cyc();
    chk("R7 R11 lowest line offered", cur_msg(), msg_w(5'd4, 8'h40, 8'h04, 0, 0));
    cyc(); chk("R11 held while not ready", cur_msg(), msg_w(5'd4, 8'h40, 8'h04, 0, 0));
    msg_ready = 1; cyc();
    chk("R11 next line after accept", cur_msg(), msg_w(5'd20, 8'hA0, 8'h14, 1, 0));
    cyc(); chk("R11 queue drained", msg_valid, 0);
    lines[4] = 0; lines[20] = 1;
    setup(4, 0, 0, 0, 0, 0, 0, 1); setup(20, 0, 0, 0, 0, 0, 0, 1); lines[20] = 0;

    setup(6, 8'h66, 8'h06, 0, 0, 0, 0, 0);
    msg_ready = 0; lines[6] = 1; cyc();
    chk("R12 first edge offered", msg_valid, 1);
    lines[6] = 0; cyc();
    msg_ready = 1; lines[6] = 1; cyc();
    chk("R12 edge at accept kept", cur_msg(), msg_w(5'd6, 8'h66, 8'h06, 0, 0));
    chk("R12 edge at accept valid", msg_valid, 1);
    cyc(); chk("R12 then drained", msg_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule